// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritizer

This block holds the interrupt state that two serial channels, A and B, share. Each channel reports single-cycle events: a received character has arrived, the transmitter has gone empty, software wrote the transmit data register, software read the received data, or software issued the command that resets the highest in-service source. For each channel the block keeps a receive-pending flag, a receive-in-service flag, a transmit-pending flag, a transmit-in-service flag and a receive-available flag. From these it drives one shared interrupt line, a pending-status byte and an interrupt vector byte. In the wider device both bytes are read through channel B's register window.

Receive service comes before transmit service. A transmitter-empty event that arrives while that channel's receive source is in service is held as pending. It is not announced. It is raised again once the receive source is released. The vector byte has two encodings, and a status-high control bit selects between them.

Top module: `serial_irq_prio`

## Requirements
- R1: `irq` is high exactly when at least one channel has a request. A channel requests when (a) its transmit enable is set and transmit is pending, or (b) its receive mode is 1 (first character) or 2 (every character) and receive is pending, or (c) its break enable and break status inputs are both high. Receive modes 0 and 3 never request.
- R2: A receive event marks that channel's receive as pending and in service, and sets its receive-available output. It sets that channel's receive bit in the pending-status byte and loads the vector with that channel's receive code.
- R3: A transmit event that arrives while the channel has no receive in service marks transmit as pending and in service, and loads the vector with that channel's transmit code. It sets the channel's transmit status bit only if the channel's transmit enable is high.
- R4: A transmit event that arrives while the same channel's receive is in service only marks transmit as pending. The vector and the pending-status byte stay unchanged.
- R5: The reset-in-service command clears receive in service if it is set, and then re-raises a pending transmit as in R3. Otherwise it clears transmit in service and leaves the vector and the status unchanged.
- R6: A receive-data read clears receive-available, receive pending and receive in service. It clears the channel's receive status bit and sets the vector to the no-interrupt code. If transmit is still pending, it then re-raises transmit as in R3.
- R7: A transmit-data write clears transmit pending and transmit in service. It clears the channel's transmit status bit and sets the vector to the no-interrupt code. If receive is still pending, it then re-raises receive as in R2.
- R8: Vector codes with `status_hi`=0 are: no interrupt 0x06, receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00. With `status_hi`=1 they are: no interrupt 0x60, receive A 0x30, transmit A 0x10, receive B 0x20, transmit B 0x00. `status_hi` takes effect on `vector` in the same cycle it changes.
- R9: The pending-status byte places receive A at bit 5, transmit A at bit 4, receive B at bit 2 and transmit B at bit 1. All other bits read 0.
- R10: While `rst_n` is low, all flags and the pending-status byte are 0, `irq` is 0 and `vector` shows the no-interrupt code of the current encoding.
- R11: Within one channel and one cycle, actions are applied in this order: transmit write, receive read, reset-in-service, receive event, transmit event. Each action sees the result of the ones before it. When both channels load the vector in the same cycle, channel B's code is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_hi | input | 1 | Selects the high (1) or low (0) vector encoding |
| tx_ie | input | 2 | Transmit interrupt enable, bit 0 = A, bit 1 = B |
| rx_mode | input | 4 | Receive interrupt mode, [1:0] = A, [3:2] = B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_st | input | 2 | Break status per channel |
| rx_event | input | 2 | Character received, one-cycle pulse per channel |
| tx_event | input | 2 | Transmitter empty, one-cycle pulse per channel |
| tx_write | input | 2 | Transmit data register written, pulse per channel |
| rx_read | input | 2 | Received data read, pulse per channel |
| reset_ius | input | 2 | Reset-highest-in-service command, pulse per channel |
| irq | output | 1 | Shared interrupt request |
| rx_avail | output | 2 | Receive-available status per channel |
| pend_status | output | 8 | Pending-status byte |
| vector | output | 8 | Interrupt vector byte |

## Verification
The hardest state to reach is a transmit event that was deferred and is later re-raised. To get there, a channel must first hold a receive in service. A transmit event then has to arrive while that receive is still in service, and only after that does a reset-in-service command or a receive-data read release the receive. The stimulus table builds this up step by step on both channels: a receive, then a deferred transmit, then a release. After each step it checks that the vector stayed frozen during the deferral and switched to the transmit code after the release. It also drives a receive read and a transmit event into the same channel in the same cycle, and receive events into both channels in the same cycle, to show the ordering of R11.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int VEC_W  = 8;
  localparam int MODE_W = 2;

  // receive interrupt modes that produce a request
  localparam logic [MODE_W-1:0] RXM_FIRST = 2'd1;
  localparam logic [MODE_W-1:0] RXM_ALL   = 2'd2;

  // pending-status bit positions (software decodes these)
  localparam int PS_RXA = 5;
  localparam int PS_TXA = 4;
  localparam int PS_RXB = 2;
  localparam int PS_TXB = 1;
  localparam logic [VEC_W-1:0] PS_USED =
    VEC_W'((1 << PS_RXA) | (1 << PS_TXA) | (1 << PS_RXB) | (1 << PS_TXB));

  // vector codes, low variant
  localparam logic [VEC_W-1:0] VLO_NONE = 8'h06;
  localparam logic [VEC_W-1:0] VLO_RXA  = 8'h0C;
  localparam logic [VEC_W-1:0] VLO_TXA  = 8'h08;
  localparam logic [VEC_W-1:0] VLO_RXB  = 8'h04;
  // vector codes, high variant
  localparam logic [VEC_W-1:0] VHI_NONE = 8'h60;
  localparam logic [VEC_W-1:0] VHI_RXA  = 8'h30;
  localparam logic [VEC_W-1:0] VHI_TXA  = 8'h10;
  localparam logic [VEC_W-1:0] VHI_RXB  = 8'h20;
  // transmit B shares one code in both variants
  localparam logic [VEC_W-1:0] V_TXB    = 8'h00;

  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_RX = 2'd1, ACT_TX = 2'd2} act_kind_e;

  typedef enum logic [2:0] {
    VK_IDLE = 3'd0, VK_RXA = 3'd1, VK_TXA = 3'd2, VK_RXB = 3'd3, VK_TXB = 3'd4
  } vkind_e;

  // per-cycle request from a channel to the shared registers
  typedef struct packed {
    logic      valid;   // load the vector
    act_kind_e kind;    // which code to load
    logic      rx_we;   // write the receive status bit
    logic      rx_val;
    logic      tx_we;   // write the transmit status bit
    logic      tx_val;
  } chan_act_t;

  typedef struct packed {
    logic rx_pend;
    logic rx_ius;
    logic tx_pend;
    logic tx_ius;
    logic rx_avail;
  } chan_flags_t;

  function automatic logic [VEC_W-1:0] vec_code(vkind_e k, logic hi);
    logic [VEC_W-1:0] c;
    case (k)
      VK_RXA:  c = hi ? VHI_RXA : VLO_RXA;
      VK_TXA:  c = hi ? VHI_TXA : VLO_TXA;
      VK_RXB:  c = hi ? VHI_RXB : VLO_RXB;
      VK_TXB:  c = V_TXB;
      default: c = hi ? VHI_NONE : VLO_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irq_prio_chan.sv
module irq_prio_chan
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ie,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic              brk_ie,
  input  logic              brk_st,
  input  logic              rx_event,
  input  logic              tx_event,
  input  logic              tx_write,
  input  logic              rx_read,
  input  logic              reset_ius,
  output logic              request,
  output logic              rx_avail,
  output chan_act_t         act
);

  typedef struct packed {
    chan_flags_t f;
    chan_act_t   a;
  } work_t;

  chan_flags_t q, d;
  work_t       w;

  function automatic work_t raise_rx(work_t s);
    work_t r = s;
    r.f.rx_pend = 1'b1;
    r.f.rx_ius  = 1'b1;
    r.a.valid   = 1'b1;
    r.a.kind    = ACT_RX;
    r.a.rx_we   = 1'b1;
    r.a.rx_val  = 1'b1;
    return r;
  endfunction

  function automatic work_t raise_tx(work_t s, logic ie);
    work_t r = s;
    r.f.tx_pend = 1'b1;
    if (!r.f.rx_ius) begin
      r.f.tx_ius = 1'b1;
      r.a.valid  = 1'b1;
      r.a.kind   = ACT_TX;
      if (ie) begin
        r.a.tx_we  = 1'b1;
        r.a.tx_val = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic work_t drop_rx(work_t s, logic ie);
    work_t r = s;
    r.f.rx_pend = 1'b0;
    r.f.rx_ius  = 1'b0;
    r.a.valid   = 1'b1;
    r.a.kind    = ACT_NONE;
    r.a.rx_we   = 1'b1;
    r.a.rx_val  = 1'b0;
    if (r.f.tx_pend) r = raise_tx(r, ie);
    return r;
  endfunction

  function automatic work_t drop_tx(work_t s);
    work_t r = s;
    r.f.tx_pend = 1'b0;
    r.f.tx_ius  = 1'b0;
    r.a.valid   = 1'b1;
    r.a.kind    = ACT_NONE;
    r.a.tx_we   = 1'b1;
    r.a.tx_val  = 1'b0;
    if (r.f.rx_pend) r = raise_rx(r);
    return r;
  endfunction

  // next state: actions applied in fixed order (R11)
  always_comb begin
    w.f = q;
    w.a = '0;
    if (tx_write) w = drop_tx(w);                      // R7
    if (rx_read) begin                                  // R6
      w.f.rx_avail = 1'b0;
      w = drop_rx(w, tx_ie);
    end
    if (reset_ius) begin                                // R5
      if (w.f.rx_ius) begin
        w.f.rx_ius = 1'b0;
        if (w.f.tx_pend) w = raise_tx(w, tx_ie);
      end else if (w.f.tx_ius) begin
        w.f.tx_ius = 1'b0;
      end
    end
    if (rx_event) begin                                 // R2
      w.f.rx_avail = 1'b1;
      w = raise_rx(w);
    end
    if (tx_event) w = raise_tx(w, tx_ie);              // R3 / R4
    d   = w.f;
    act = w.a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // request terms (R1)
  logic rx_mode_on;
  assign rx_mode_on = (rx_mode == RXM_FIRST) || (rx_mode == RXM_ALL);
  assign request  = (tx_ie & q.tx_pend) | (rx_mode_on & q.rx_pend) | (brk_ie & brk_st);
  assign rx_avail = q.rx_avail;

  a_r2_rx_marks: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> (q.rx_pend && q.rx_ius && q.rx_avail));

  a_r4_tx_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_event && q.rx_ius && !tx_write && !rx_read && !reset_ius && !rx_event)
      |=> (q.tx_pend && $stable(q.tx_ius)));

  a_r5_rx_ius_released: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_ius && q.rx_ius && !rx_event && !tx_write) |=> !q.rx_ius);

  a_r7_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !tx_event && !rx_read && !reset_ius) |=> (!q.tx_pend && !q.tx_ius));

  a_r6_avail_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !rx_event) |=> !q.rx_avail);

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_hi,
  input  chan_act_t        act_a,
  input  chan_act_t        act_b,
  output logic [VEC_W-1:0] pend_status,
  output logic [VEC_W-1:0] vector
);

  localparam int NCH = 2;

  vkind_e           kind_q, kind_d;
  logic [VEC_W-1:0] stat_q, stat_d;
  chan_act_t        acts [NCH];

  assign acts[0] = act_a;
  assign acts[1] = act_b;

  function automatic vkind_e map_kind(act_kind_e k, int ch);
    vkind_e r;
    case (k)
      ACT_RX:  r = (ch == 0) ? VK_RXA : VK_RXB;
      ACT_TX:  r = (ch == 0) ? VK_TXA : VK_TXB;
      default: r = VK_IDLE;
    endcase
    return r;
  endfunction

  // vector kind: channel A first, channel B last so B wins (R11)
  always_comb begin
    kind_d = kind_q;
    for (int ch = 0; ch < NCH; ch++) begin
      if (acts[ch].valid) kind_d = map_kind(acts[ch].kind, ch);
    end
  end

  // status bits, one slice per channel (R9)
  logic [NCH-1:0][VEC_W-1:0] stat_upd;
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_stat
      localparam int RXB = (g == 0) ? PS_RXA : PS_RXB;
      localparam int TXB = (g == 0) ? PS_TXA : PS_TXB;
      always_comb begin
        stat_upd[g] = '0;
        stat_upd[g][RXB] = acts[g].rx_we ? acts[g].rx_val : stat_q[RXB];
        stat_upd[g][TXB] = acts[g].tx_we ? acts[g].tx_val : stat_q[TXB];
      end
    end
  endgenerate

  always_comb begin
    stat_d = '0;
    for (int ch = 0; ch < NCH; ch++) stat_d = stat_d | stat_upd[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= VK_IDLE;
      stat_q <= '0;
    end else begin
      kind_q <= kind_d;
      stat_q <= stat_d;
    end
  end

  // encoding applied at the output, so it follows status_hi at once (R8, R10)
  assign vector      = vec_code(kind_q, status_hi);
  assign pend_status = stat_q;

  a_r11_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a.valid && act_b.valid)
      |=> (kind_q == VK_RXB || kind_q == VK_TXB || kind_q == VK_IDLE));

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_status & ~PS_USED) == '0);

  a_r2_rx_b_status: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b.valid && act_b.kind == ACT_RX) |=> pend_status[PS_RXB]);

endmodule

// File: rtl/serial_irq_prio.sv
module serial_irq_prio
  import irq_prio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                status_hi,
  input  logic [1:0]          tx_ie,
  input  logic [2*MODE_W-1:0] rx_mode,
  input  logic [1:0]          brk_ie,
  input  logic [1:0]          brk_st,
  input  logic [1:0]          rx_event,
  input  logic [1:0]          tx_event,
  input  logic [1:0]          tx_write,
  input  logic [1:0]          rx_read,
  input  logic [1:0]          reset_ius,
  output logic                irq,
  output logic [1:0]          rx_avail,
  output logic [VEC_W-1:0]    pend_status,
  output logic [VEC_W-1:0]    vector
);

  localparam int NCH = 2;

  chan_act_t        act [NCH];
  logic [NCH-1:0]   req;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      irq_prio_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_ie     (tx_ie[g]),
        .rx_mode   (rx_mode[g*MODE_W +: MODE_W]),
        .brk_ie    (brk_ie[g]),
        .brk_st    (brk_st[g]),
        .rx_event  (rx_event[g]),
        .tx_event  (tx_event[g]),
        .tx_write  (tx_write[g]),
        .rx_read   (rx_read[g]),
        .reset_ius (reset_ius[g]),
        .request   (req[g]),
        .rx_avail  (rx_avail[g]),
        .act       (act[g])
      );
    end
  endgenerate

  irq_prio_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_hi   (status_hi),
    .act_a       (act[0]),
    .act_b       (act[1]),
    .pend_status (pend_status),
    .vector      (vector)
  );

  assign irq = |req;

  a_r1_break_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(brk_ie & brk_st)) |-> irq);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_status == '0) && (rx_avail == '0) && !(|(brk_ie & brk_st))
      && !(|tx_ie)) |-> !irq);

endmodule

// File: tb/serial_irq_prio_test.sv
`timescale 1ns/1ps
module serial_irq_prio_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       status_hi;
  logic [1:0] tx_ie, brk_ie, brk_st, rx_event, tx_event, tx_write, rx_read, reset_ius;
  logic [3:0] rx_mode;
  logic       irq;
  logic [1:0] rx_avail;
  logic [7:0] pend_status, vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  serial_irq_prio uut (
    .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .tx_ie(tx_ie),
    .rx_mode(rx_mode), .brk_ie(brk_ie), .brk_st(brk_st),
    .rx_event(rx_event), .tx_event(tx_event), .tx_write(tx_write),
    .rx_read(rx_read), .reset_ius(reset_ius), .irq(irq),
    .rx_avail(rx_avail), .pend_status(pend_status), .vector(vector)
  );

  // pulse bits
  localparam logic [9:0] RXA = 10'h200, RXB = 10'h100, TXA = 10'h080, TXB = 10'h040;
  localparam logic [9:0] TWA = 10'h020, TWB = 10'h010, RRA = 10'h008, RRB = 10'h004;
  localparam logic [9:0] RIA = 10'h002, RIB = 10'h001, NOP = 10'h000;

  // row: req[38:35] shi[34] tia[33] rma[32:31] bieb[30] bstb[29] pulses[28:19]
  //      irq[18] avail[17:16] status[15:8] vector[7:0]
  function automatic logic [38:0] mk(int rq, bit shi, bit tia, logic [1:0] rma, bit bie,
                                     bit bst, logic [9:0] p, bit ei, logic [1:0] ea,
                                     logic [7:0] es, logic [7:0] ev);
    return {4'(rq), shi, tia, rma, bie, bst, p, ei, ea, es, ev};
  endfunction

  localparam int NSTEP = 24;
  localparam logic [38:0] STEPS [NSTEP] = '{
    mk(2,  0,1,2'd1,0,0, RXA,       1,2'b01,8'h20,8'h0C), // R2 receive A
    mk(4,  0,1,2'd1,0,0, TXA,       1,2'b01,8'h20,8'h0C), // R4 deferred transmit
    mk(5,  0,1,2'd1,0,0, RIA,       1,2'b01,8'h30,8'h08), // R5 re-raise transmit
    mk(6,  0,1,2'd1,0,0, RRA,       1,2'b00,8'h10,8'h08), // R6 read then re-raise
    mk(7,  0,1,2'd1,0,0, TWA,       0,2'b00,8'h00,8'h06), // R7 transmit write
    mk(9,  0,1,2'd1,0,0, RXB,       1,2'b10,8'h04,8'h04), // R9 receive B bit 2
    mk(8,  1,1,2'd1,0,0, NOP,       1,2'b10,8'h04,8'h20), // R8 high encoding
    mk(4,  1,1,2'd1,0,0, TXB,       1,2'b10,8'h04,8'h20), // R4 on channel B
    mk(5,  1,1,2'd1,0,0, RIB,       1,2'b10,8'h06,8'h00), // R5 transmit B code
    mk(7,  1,1,2'd1,0,0, TWB,       1,2'b10,8'h04,8'h20), // R7 re-raise receive
    mk(6,  1,1,2'd1,0,0, RRB,       0,2'b00,8'h00,8'h60), // R6 high no-interrupt
    mk(8,  0,1,2'd1,0,0, NOP,       0,2'b00,8'h00,8'h06), // R8 back to low
    mk(3,  0,0,2'd1,0,0, TXA,       0,2'b00,8'h00,8'h08), // R3 enable off, no bit
    mk(1,  0,1,2'd1,0,0, NOP,       1,2'b00,8'h00,8'h08), // R1 enable on
    mk(5,  0,1,2'd1,0,0, RIA,       1,2'b00,8'h00,8'h08), // R5 tx ius cleared only
    mk(7,  0,1,2'd1,0,0, TWA,       0,2'b00,8'h00,8'h06), // R7
    mk(1,  0,1,2'd0,0,0, RXA,       0,2'b01,8'h20,8'h0C), // R1 mode 0 silent
    mk(1,  0,1,2'd3,0,0, NOP,       0,2'b01,8'h20,8'h0C), // R1 mode 3 silent
    mk(1,  0,1,2'd2,0,0, NOP,       1,2'b01,8'h20,8'h0C), // R1 mode 2 requests
    mk(6,  0,1,2'd1,0,0, RRA,       0,2'b00,8'h00,8'h06), // R6
    mk(1,  0,1,2'd1,1,1, NOP,       1,2'b00,8'h00,8'h06), // R1 break
    mk(1,  0,1,2'd1,0,1, NOP,       0,2'b00,8'h00,8'h06), // R1 break masked
    mk(11, 0,1,2'd1,0,0, RXA|RXB,   1,2'b11,8'h24,8'h04), // R11 B wins vector
    mk(11, 0,1,2'd1,0,0, RRA|TXA,   1,2'b10,8'h14,8'h08)  // R11 read before tx event
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_event = '0; tx_event = '0; tx_write = '0; rx_read = '0; reset_ius = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; status_hi = 1'b0; tx_ie = 2'b11; rx_mode = {2'd2, 2'd1};
    brk_ie = '0; brk_st = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 irq", {7'd0, irq}, 8'h00);
    check("R10 status", pend_status, 8'h00);
    check("R10 vector", vector, 8'h06);
    check("R10 avail", {6'd0, rx_avail}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      logic [38:0] s;
      string tag;
      s = STEPS[i];
      status_hi  = s[34];
      tx_ie      = {1'b1, s[33]};
      rx_mode    = {2'd2, s[32:31]};
      brk_ie     = {s[30], 1'b0};
      brk_st     = {s[29], 1'b0};
      rx_event   = {s[27], s[28]};
      tx_event   = {s[25], s[26]};
      tx_write   = {s[23], s[24]};
      rx_read    = {s[21], s[22]};
      reset_ius  = {s[19], s[20]};
      @(negedge clk);
      idle_inputs();
      tag = $sformatf("R%0d step %0d", s[38:35], i);
      check({tag, " irq"}, {7'd0, irq}, {7'd0, s[18]});
      check({tag, " avail"}, {6'd0, rx_avail}, {6'd0, s[17:16]});
      check({tag, " status"}, pend_status, s[15:8]);
      check({tag, " vector"}, vector, s[7:0]);
    end

    // R10 reset from a busy state, high encoding
    status_hi = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R10 busy reset irq", {7'd0, irq}, 8'h00);
    check("R10 busy reset status", pend_status, 8'h00);
    check("R10 busy reset vector", vector, 8'h60);
    check("R10 busy reset avail", {6'd0, rx_avail}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    status_hi = 1'b0;
    @(negedge clk);
    check("R10 after release vector", vector, 8'h06);

    // R3 transmit A on idle channel with enable: bit 4 and code 0x08
    tx_event = 2'b01;
    @(negedge clk);
    idle_inputs();
    check("R3 status", pend_status, 8'h10);
    check("R3 vector", vector, 8'h08);
    check("R3 irq", {7'd0, irq}, 8'h01);
    // R8 high code for transmit A
    status_hi = 1'b1;
    #1;
    check("R8 transmit A high", vector, 8'h10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule